// File: doc/BRIEF.md
# MESI Snooping Line State Controller

This block keeps the coherence state of every line of a direct-mapped, write-back cache on a snooping bus that several caches share. Each line is Modified, Exclusive, Shared or Invalid, and the block keeps a tag beside each state. The processor side accepts one read or write at a time. Hits are answered locally. Misses, and writes to a Shared line, go out as bus commands after the arbiter grants the bus.

The snoop side watches the transactions of the other caches. It downgrades or invalidates matching lines. It answers through a wired-OR shared line, and it reports a write-back when it is asked for a dirty copy. The shared line is sampled one cycle after the address phase of the block's own read. A read miss therefore fills as Exclusive when no other cache holds the line and as Shared when one does. Exclusive lines then become Modified on a write with no bus traffic.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: a snoop to any address gets no response and any access misses.
- R2: A read miss issues one bus read (command code 0) for the requested address. The line fills as Exclusive when the shared input is low in the cycle after that command, and as Shared when it is high.
- R3: A write miss issues one bus read-for-ownership (command code 1) and leaves the line Modified.
- R4: A write hit on an Exclusive line makes it Modified with no bus request, and completes in one cycle.
- R5: A write hit on a Shared line issues an address-only invalidate (command code 2) for that address and leaves the line Modified.
- R6: A read hit completes one cycle after the request is accepted, with no bus request.
- R7: A miss whose victim is Modified first issues a write-back (command code 3) carrying the victim's address. The fill command follows in the next cycle.
- R8: A snooped bus read that hits a valid line raises the shared output in the next cycle and leaves the line Shared. A Modified line also raises the write-back output.
- R9: A snooped read-for-ownership that hits a valid line invalidates it, without raising the shared output. A Modified line raises the write-back output.
- R10: A snooped invalidate that hits a Shared line makes it Invalid.
- R11: A snoop whose tag differs from the stored tag, or that finds the line Invalid, produces no response and changes nothing.
- R12: The bus command is chosen in the grant cycle, from the line state at that time. Snoops that land while the request waits for the grant are therefore taken into account.
- R13: The bus request stays high until the grant arrives. No command is driven before the grant, and the request drops once the access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor access pending; held until req_done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Line address: tag above, set index in the low IDX_W bits |
| req_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Bus granted |
| bus_valid | output | 1 | Address phase of an issued command |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_addr | output | ADDR_W | Line address of the issued command |
| shared_in | input | 1 | Wired-OR shared line from the other caches |
| snp_valid | input | 1 | Another cache's address phase |
| snp_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | Shared response, one cycle after the snoop |
| snp_wb | output | 1 | Dirty-copy write-back response, one cycle after the snoop |

## Verification
The hardest situation to bring about is a snoop that changes a line while the block's own request is waiting for the grant. In one case a Shared line, waiting to be upgraded, is invalidated by another cache. In the other, a dirty victim is taken away by an intervention before it can be evicted. The stimulus holds the grant low after a request has entered the wait. It injects the snoop on the snoop port and then releases the grant. The only bus command must then be the read-for-ownership or the plain read, with no invalidate and no write-back. Every set is taken through the full state cycle with distinct tags, so each transition is seen in every index.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
   typedef enum logic [1:0] {
      ST_I = 2'd0,
      ST_S = 2'd1,
      ST_E = 2'd2,
      ST_M = 2'd3
   } line_st_e;

   typedef enum logic [1:0] {
      CMD_RD  = 2'd0,
      CMD_RDX = 2'd1,
      CMD_INV = 2'd2,
      CMD_WB  = 2'd3
   } bus_cmd_e;

   typedef enum logic [2:0] {
      MS_IDLE,
      MS_ARB,
      MS_WB,
      MS_CMD,
      MS_RESP,
      MS_DONE
   } mst_st_e;
endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
   import mesi_pkg::*;
#(
   parameter int IDX_W = 2,
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] a_idx,
   output line_st_e         a_st,
   output logic [TAG_W-1:0] a_tag,
   input  logic [IDX_W-1:0] b_idx,
   output line_st_e         b_st,
   output logic [TAG_W-1:0] b_tag,
   input  logic             m_we,
   input  logic [IDX_W-1:0] m_idx,
   input  line_st_e         m_st,
   input  logic [TAG_W-1:0] m_tag,
   input  logic             s_we,
   input  logic [IDX_W-1:0] s_idx,
   input  line_st_e         s_st
);
   localparam int SETS = 1 << IDX_W;

   line_st_e         st_q  [SETS];
   logic [TAG_W-1:0] tag_q [SETS];

   always_ff @(posedge clk) begin
      for (int k = 0; k < SETS; k++) begin
         if (!rst_n) begin
            st_q[k]  <= ST_I;
            tag_q[k] <= '0;
         end else begin
            if (s_we && s_idx == k[IDX_W-1:0])
               st_q[k] <= s_st;
            else if (m_we && m_idx == k[IDX_W-1:0])
               st_q[k] <= m_st;
            if (m_we && m_idx == k[IDX_W-1:0])
               tag_q[k] <= m_tag;
         end
      end
   end

   assign a_st  = st_q[a_idx];
   assign a_tag = tag_q[a_idx];
   assign b_st  = st_q[b_idx];
   assign b_tag = tag_q[b_idx];

   // master and snoop never update the same set in one cycle
   p_no_dual_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_we && s_we && m_idx == s_idx));
endmodule

// File: rtl/mesi_snoop.sv
module mesi_snoop
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic [IDX_W-1:0]  l_idx,
   input  line_st_e          l_st,
   input  logic [ADDR_W-IDX_W-1:0] l_tag,
   output logic              s_we,
   output line_st_e          s_st,
   output logic              snp_shared,
   output logic              snp_wb
);
   localparam int TAG_W = ADDR_W - IDX_W;

   logic [TAG_W-1:0] stag;
   logic             hit, shd_d, wb_d;
   bus_cmd_e         cmd;

   always_comb begin
      l_idx = snp_addr[IDX_W-1:0];
      stag  = snp_addr[ADDR_W-1:IDX_W];
      cmd   = bus_cmd_e'(snp_cmd);
      hit   = snp_valid && (l_st != ST_I) && (l_tag == stag);
      s_we  = 1'b0;
      s_st  = l_st;
      shd_d = 1'b0;
      wb_d  = 1'b0;
      if (hit) begin
         unique case (cmd)
            CMD_RD: begin
               s_we  = (l_st != ST_S);
               s_st  = ST_S;
               shd_d = 1'b1;
               wb_d  = (l_st == ST_M);
            end
            CMD_RDX: begin
               s_we = 1'b1;
               s_st = ST_I;
               wb_d = (l_st == ST_M);
            end
            CMD_INV: begin
               if (l_st == ST_S) begin
                  s_we = 1'b1;
                  s_st = ST_I;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snp_shared <= 1'b0;
         snp_wb     <= 1'b0;
      end else begin
         snp_shared <= shd_d;
         snp_wb     <= wb_d;
      end
   end

   p_shared_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      snp_shared |-> ($past(snp_valid) && $past(snp_cmd) == CMD_RD));
   p_wb_after_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      snp_wb |-> ($past(snp_valid) && ($past(snp_cmd) == CMD_RD || $past(snp_cmd) == CMD_RDX)));
endmodule

// File: rtl/mesi_master.sv
module mesi_master
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_done,
   output logic [IDX_W-1:0]  l_idx,
   input  line_st_e          l_st,
   input  logic [ADDR_W-IDX_W-1:0] l_tag,
   input  logic              snp_conflict,
   output logic              m_we,
   output line_st_e          m_st,
   output logic [ADDR_W-IDX_W-1:0] m_tag,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              bus_valid,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              shared_in
);
   localparam int TAG_W = ADDR_W - IDX_W;

   mst_st_e           fsm_q, fsm_d;
   logic [ADDR_W-1:0] addr_q, vic_q;
   logic              wr_q;
   bus_cmd_e          cmd_q;
   logic              ld_req, ld_dec;
   bus_cmd_e          cmd_d;
   logic              hit, in_idle;
   logic [TAG_W-1:0]  cur_tag;

   assign in_idle = (fsm_q == MS_IDLE);
   assign l_idx   = in_idle ? req_addr[IDX_W-1:0] : addr_q[IDX_W-1:0];
   assign cur_tag = in_idle ? req_addr[ADDR_W-1:IDX_W] : addr_q[ADDR_W-1:IDX_W];
   assign hit     = (l_st != ST_I) && (l_tag == cur_tag);

   always_comb begin
      fsm_d  = fsm_q;
      ld_req = 1'b0;
      ld_dec = 1'b0;
      cmd_d  = cmd_q;
      m_we   = 1'b0;
      m_st   = l_st;
      m_tag  = cur_tag;
      unique case (fsm_q)
         MS_IDLE: begin
            if (req_valid && !snp_conflict) begin
               if (hit && (!req_write || l_st != ST_S)) begin
                  m_we  = req_write && (l_st == ST_E);
                  m_st  = ST_M;
                  fsm_d = MS_DONE;
               end else begin
                  ld_req = 1'b1;
                  fsm_d  = MS_ARB;
               end
            end
         end
         MS_ARB: begin
            if (bus_gnt && !snp_conflict) begin
               ld_dec = 1'b1;
               if (wr_q) cmd_d = hit ? CMD_INV : CMD_RDX;
               else      cmd_d = CMD_RD;
               fsm_d = (!hit && l_st == ST_M) ? MS_WB : MS_CMD;
            end
         end
         MS_WB:  fsm_d = MS_CMD;
         MS_CMD: fsm_d = MS_RESP;
         MS_RESP: begin
            m_we  = 1'b1;
            m_st  = (cmd_q == CMD_RD) ? (shared_in ? ST_S : ST_E) : ST_M;
            fsm_d = MS_DONE;
         end
         MS_DONE: fsm_d = MS_IDLE;
         default: fsm_d = MS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsm_q  <= MS_IDLE;
         addr_q <= '0;
         vic_q  <= '0;
         wr_q   <= 1'b0;
         cmd_q  <= CMD_RD;
      end else begin
         fsm_q <= fsm_d;
         if (ld_req) begin
            addr_q <= req_addr;
            wr_q   <= req_write;
         end
         if (ld_dec) begin
            cmd_q <= cmd_d;
            vic_q <= {l_tag, addr_q[IDX_W-1:0]};
         end
      end
   end

   always_comb begin
      req_done  = (fsm_q == MS_DONE);
      bus_req   = (fsm_q == MS_ARB) || (fsm_q == MS_WB) ||
                  (fsm_q == MS_CMD) || (fsm_q == MS_RESP);
      bus_valid = (fsm_q == MS_WB) || (fsm_q == MS_CMD);
      bus_cmd   = (fsm_q == MS_WB) ? CMD_WB : cmd_q;
      bus_addr  = (fsm_q == MS_WB) ? vic_q : addr_q;
   end

   p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_cmd == CMD_WB) |=>
      (bus_valid && (bus_cmd == CMD_RD || bus_cmd == CMD_RDX)));
   p_req_held_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt && !bus_valid) |=> bus_req);
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> !req_done);
   p_inv_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_cmd == CMD_INV) |-> wr_q);
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_done,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              bus_valid,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              shared_in,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_shared,
   output logic              snp_wb
);
   localparam int TAG_W = ADDR_W - IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
         $error("IDX_W out of range");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("ADDR_W must exceed IDX_W");
      end
   endgenerate

   logic [IDX_W-1:0] a_idx, b_idx;
   line_st_e         a_st, b_st, m_st, s_st;
   logic [TAG_W-1:0] a_tag, b_tag, m_tag;
   logic             m_we, s_we, snp_conflict;

   assign snp_conflict = s_we && (b_idx == a_idx);

   mesi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
      .clk(clk), .rst_n(rst_n),
      .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag),
      .b_idx(b_idx), .b_st(b_st), .b_tag(b_tag),
      .m_we(m_we), .m_idx(a_idx), .m_st(m_st), .m_tag(m_tag),
      .s_we(s_we), .s_idx(b_idx), .s_st(s_st)
   );

   mesi_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snoop (
      .clk(clk), .rst_n(rst_n),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .l_idx(b_idx), .l_st(b_st), .l_tag(b_tag),
      .s_we(s_we), .s_st(s_st),
      .snp_shared(snp_shared), .snp_wb(snp_wb)
   );

   mesi_master #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_master (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_done(req_done),
      .l_idx(a_idx), .l_st(a_st), .l_tag(a_tag),
      .snp_conflict(snp_conflict),
      .m_we(m_we), .m_st(m_st), .m_tag(m_tag),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid),
      .bus_cmd(bus_cmd), .bus_addr(bus_addr), .shared_in(shared_in)
   );
endmodule

// File: tb/tb_mesi_line_ctrl.sv
`timescale 1ns/1ps
module tb_mesi_line_ctrl;
   localparam int ADDR_W = 8;
   localparam int IDX_W  = 2;
   localparam int C_RD = 0, C_RDX = 1, C_INV = 2, C_WB = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic req_done, bus_req, bus_valid, snp_shared, snp_wb;
   logic bus_gnt = 1'b1, shared_in = 1'b0, snp_valid = 1'b0;
   logic [1:0] bus_cmd, snp_cmd = '0;
   logic [ADDR_W-1:0] bus_addr, snp_addr = '0;

   int n_chk = 0, n_fail = 0;
   int n_log = 0;
   int log_cmd [8];
   int log_addr[8];
   bit finished = 1'b0;

   always #4 clk = ~clk;

   mesi_line_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_done(req_done), .bus_req(bus_req),
      .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
      .bus_addr(bus_addr), .shared_in(shared_in), .snp_valid(snp_valid),
      .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_shared(snp_shared),
      .snp_wb(snp_wb));

   always @(negedge clk) begin
      if (rst_n && bus_valid && n_log < 8) begin
         log_cmd[n_log]  = int'(bus_cmd);
         log_addr[n_log] = int'(bus_addr);
         n_log++;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic start_req(input bit w, input int addr, input bit shd);
      @(negedge clk);
      n_log     = 0;
      req_valid = 1'b1;
      req_write = w;
      req_addr  = addr[ADDR_W-1:0];
      shared_in = shd;
   endtask

   task automatic finish_req(output int ncyc);
      ncyc = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         ncyc++;
         if (req_done) break;
      end
      if (!req_done) check("TIMEOUT", 0, 1);
      req_valid = 1'b0;
   endtask

   task automatic access(input bit w, input int addr, input bit shd, output int ncyc);
      start_req(w, addr, shd);
      finish_req(ncyc);
   endtask

   task automatic snoop(input string req, input int cmd, input int addr,
                        input bit e_shd, input bit e_wb);
      @(negedge clk);
      snp_valid = 1'b1;
      snp_cmd   = cmd[1:0];
      snp_addr  = addr[ADDR_W-1:0];
      @(negedge clk);
      snp_valid = 1'b0;
      check({req, " shared"}, int'(snp_shared), int'(e_shd));
      check({req, " wb"}, int'(snp_wb), int'(e_wb));
   endtask

   task automatic chk_log(input string req, input int n, input int c0, input int a0,
                          input int c1, input int a1);
      check({req, " bus count"}, n_log, n);
      if (n >= 1 && n_log >= 1) begin
         check({req, " cmd0"}, log_cmd[0], c0);
         check({req, " addr0"}, log_addr[0], a0);
      end
      if (n >= 2 && n_log >= 2) begin
         check({req, " cmd1"}, log_cmd[1], c1);
         check({req, " addr1"}, log_addr[1], a1);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int nc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 done", int'(req_done), 0);
      check("R13 req", int'(bus_req), 0);
      check("R13 valid", int'(bus_valid), 0);

      for (int i = 0; i < (1 << IDX_W); i++) begin
         int t, a, b;
         t = i * 5 + 1;
         a = (t << IDX_W) | i;
         b = ((t + 17) << IDX_W) | i;
         // R1: every set starts invalid
         snoop("R1", C_RD, a, 1'b0, 1'b0);
         // R2: read miss, no sharer -> Exclusive
         access(1'b0, a, 1'b0, nc);
         chk_log("R2 rd miss", 1, C_RD, a, 0, 0);
         check("R2 latency", nc, 4);
         // R4: silent upgrade
         access(1'b1, a, 1'b0, nc);
         chk_log("R4 silent", 0, 0, 0, 0, 0);
         check("R4 latency", nc, 1);
         // R8: snoop read on Modified
         snoop("R8 M", C_RD, a, 1'b1, 1'b1);
         // R5: write hit on Shared
         access(1'b1, a, 1'b0, nc);
         chk_log("R5 inv", 1, C_INV, a, 0, 0);
         // R9: snoop rdx on Modified
         snoop("R9 M", C_RDX, a, 1'b0, 1'b1);
         // R11: now invalid, no response
         snoop("R11 inv line", C_RD, a, 1'b0, 1'b0);
         // R2: read miss with sharer -> Shared
         access(1'b0, a, 1'b1, nc);
         chk_log("R2 shared fill", 1, C_RD, a, 0, 0);
         // R6: read hit
         access(1'b0, a, 1'b0, nc);
         chk_log("R6 hit", 0, 0, 0, 0, 0);
         check("R6 latency", nc, 1);
         // R10: snooped invalidate on Shared; then R3 write miss
         snoop("R10", C_INV, a, 1'b0, 1'b0);
         access(1'b1, a, 1'b0, nc);
         chk_log("R10 R3 wr miss", 1, C_RDX, a, 0, 0);
         // R7: dirty eviction
         access(1'b0, b, 1'b0, nc);
         chk_log("R7 evict", 2, C_WB, a, C_RD, b);
         check("R7 latency", nc, 5);
         // R11: old tag gone, R8 on Exclusive
         snoop("R11 tag", C_RD, a, 1'b0, 1'b0);
         snoop("R8 E", C_RD, b, 1'b1, 1'b0);
         // R12: Shared line invalidated while waiting for grant
         bus_gnt = 1'b0;
         start_req(1'b1, b, 1'b0);
         repeat (2) @(negedge clk);
         check("R13 held", int'(bus_req), 1);
         check("R13 no cmd", int'(bus_valid), 0);
         snoop("R12 inv wait", C_INV, b, 1'b0, 1'b0);
         bus_gnt = 1'b1;
         finish_req(nc);
         chk_log("R12 upgrade", 1, C_RDX, b, 0, 0);
         @(negedge clk);
         check("R13 release", int'(bus_req), 0);
         // R12: dirty victim taken by intervention while waiting
         bus_gnt = 1'b0;
         start_req(1'b0, a, 1'b0);
         repeat (2) @(negedge clk);
         snoop("R12 intervene", C_RD, b, 1'b1, 1'b1);
         bus_gnt = 1'b1;
         finish_req(nc);
         chk_log("R12 no wb", 1, C_RD, a, 0, 0);
         // R9 on Exclusive: invalidated, no wb
         snoop("R9 E", C_RDX, a, 1'b0, 1'b0);
         access(1'b0, a, 1'b0, nc);
         chk_log("R9 refetch", 1, C_RD, a, 0, 0);
         snoop("R9 clean", C_RDX, a, 1'b0, 1'b0);
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule